// File: doc/BRIEF.md
# Programmable Rank-Order Filter

This block keeps a sliding window of the most recent input words and outputs the word of a chosen rank within that window. Rank 1 gives the largest word. A rank equal to the window size gives the smallest. The middle rank of an odd window gives the median. Both the rank and the number of words in the window are set at run time, so one instance serves as a maximum, minimum or median filter, or anything in between.

The selection is done one bit-plane at a time, from the most significant plane down to the least significant. In each plane, a vote decides the result bit: the bit is 1 when at least `rank_k` of the active words carry a 1 there. A word that is still a candidate but disagrees with the vote drops out of the race. Its disagreeing bit is then copied into all of its lower bits, so that it keeps voting on the losing side.

Each plane is followed by a pipeline register. The lower bits of every word move down the pipeline in step with the vote, which skews them into the array. The result bits collect as they are decided, which deskews them. A new window is accepted every clock.

Top module: `rank_order_filter`

## Requirements
- R1: For each accepted window, `out_word` equals the `rank_k`-th largest of the `win_size` most recent accepted words, with rank 1 being the largest.
- R2: The result for a window accepted at clock edge E appears on `out_valid`/`out_word` directly after edge E+W-1. When no result is due, `out_valid` is 0.
- R3: No result is produced until at least `win_size` words have been accepted since reset.
- R4: While `rst_n` is 0, `out_valid` is 0. Reset discards words held in the window and results in flight, and the fill count starts again from zero.
- R5: `rank_k` and `win_size` are sampled with each accepted word and travel with that window. A change affects only windows accepted after it. Inputs must satisfy 1 ≤ `win_size` ≤ M and 1 ≤ `rank_k` ≤ `win_size` whenever `in_valid` is 1.
- R6: `rank_k` = 1 yields the window maximum, and `rank_k` = `win_size` yields the window minimum.
- R7: When several words in the window share a value, that value is returned at every rank it covers.
- R8: Words older than the `win_size` most recent words have no effect on the result, even when they are still held in the window storage.
- R9: The word offered on `in_word` is taken into the window exactly on the clock edges where `in_valid` is 1. On other edges the window and the fill count are unchanged, and no result is launched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Accept `in_word` into the window this edge |
| in_word | input | W | New sample |
| rank_k | input | $clog2(M+1) | Rank to select, where 1 is the largest |
| win_size | input | $clog2(M+1) | Number of most recent words that take part |
| out_valid | output | 1 | `out_word` holds a result |
| out_word | output | W | Selected word |

## Verification
The assertions take for granted that every accepted word arrives with a window size between 1 and M and a rank between 1 and that size. They check these limits on `in_valid` edges and add timing checks on the output side. The stimulus table and the directed sequences only ever pair a rank with a window size that satisfy these limits. They change the rank and size only on accepted words, and they put idle gaps and a reset in between. The bench model recomputes every expected result by sorting its own copy of the newest words.

// File: rtl/rank_order_filter.sv
module rank_order_filter #(
  parameter int W = 8,
  parameter int M = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [W-1:0]             in_word,
  input  logic [$clog2(M+1)-1:0]   rank_k,
  input  logic [$clog2(M+1)-1:0]   win_size,
  output logic                     out_valid,
  output logic [W-1:0]             out_word
);
  localparam int CW = $clog2(M+1);

  // stage 0 is the window itself; stage p holds planes p.. still to decide
  logic [W-1:0]  d_s   [W][M];
  logic          sel_s [W][M];
  logic [W-1:0]  res_s [W];
  logic [CW-1:0] k_s   [W];
  logic [CW-1:0] ws_s  [W];
  logic          v_s   [W];
  logic [CW-1:0] fill;

  logic [W-1:0]  nd    [W][M];
  logic          nsel  [W][M];
  logic [W-1:0]  nres  [W];
  logic          vote  [W];
  int            cnt;

  always_comb begin
    for (int p = 0; p < W; p++) begin
      cnt = 0;
      for (int i = 0; i < M; i++)
        if (i < int'(ws_s[p])) cnt = cnt + int'(d_s[p][i][W-1-p]);
      vote[p] = (cnt >= int'(k_s[p]));
      nres[p] = res_s[p];
      nres[p][W-1-p] = vote[p];
      for (int i = 0; i < M; i++) begin
        nd[p][i]   = d_s[p][i];
        nsel[p][i] = sel_s[p][i] & (d_s[p][i][W-1-p] == vote[p]);
        for (int j = 0; j < W; j++)
          if (j < W-1-p && sel_s[p][i] && (d_s[p][i][W-1-p] != vote[p]))
            nd[p][i][j] = d_s[p][i][W-1-p];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill <= '0;
      for (int p = 0; p < W; p++) begin
        v_s[p]   <= 1'b0;
        k_s[p]   <= '0;
        ws_s[p]  <= '0;
        res_s[p] <= '0;
        for (int i = 0; i < M; i++) begin
          d_s[p][i]   <= '0;
          sel_s[p][i] <= 1'b1;
        end
      end
    end else begin
      if (in_valid) begin
        d_s[0][0] <= in_word;
        for (int i = 1; i < M; i++) d_s[0][i] <= d_s[0][i-1];
        if (int'(fill) < M) fill <= fill + 1'b1;
        k_s[0]  <= rank_k;
        ws_s[0] <= win_size;
      end
      v_s[0] <= in_valid && (int'(fill) + 1 >= int'(win_size));
      for (int p = 1; p < W; p++) begin
        d_s[p]   <= nd[p-1];
        sel_s[p] <= nsel[p-1];
        res_s[p] <= nres[p-1];
        k_s[p]   <= k_s[p-1];
        ws_s[p]  <= ws_s[p-1];
        v_s[p]   <= v_s[p-1];
      end
    end
  end

  assign out_valid = v_s[W-1];
  assign out_word  = nres[W-1];
endmodule

// File: rtl/rof_checker.sv
module rof_checker #(
  parameter int W = 8,
  parameter int M = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic [$clog2(M+1)-1:0] rank_k,
  input logic [$clog2(M+1)-1:0] win_size,
  input logic                   out_valid,
  input logic [W-1:0]           out_word
);
  int cyc, accs, outs;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc <= 0; accs <= 0; outs <= 0;
    end else begin
      if (cyc < W) cyc <= cyc + 1;
      if (in_valid) accs <= accs + 1;
      if (out_valid) outs <= outs + 1;
    end
  end

  assert_size_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (win_size >= 1 && int'(win_size) <= M));

  assert_rank_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (rank_k >= 1 && rank_k <= win_size));

  assert_no_early_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> cyc >= W);

  assert_results_not_above_accepts_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> outs < accs);

  assert_result_known_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !$isunknown(out_word));
endmodule

bind rank_order_filter rof_checker #(.W(W), .M(M)) u_rof_checker (.*);

// File: tb/tb_rank_order_filter.sv
module tb_rank_order_filter;
  localparam int W = 8;
  localparam int M = 8;
  localparam int CW = $clog2(M+1);
  localparam int N = 22;

  localparam int    TW  [N] = '{184,105,194,117, 75,200,  5,  6,  7,  8, 10, 20, 30, 40,255,  0,128, 50, 50, 50,  1,  2};
  localparam int    TK  [N] = '{  3,  3,  3,  3,  3,  3,  2,  2,  2,  2,  1,  2,  3,  1,  1,  8,  4,  1,  2,  3,  1,  2};
  localparam int    TS  [N] = '{  5,  5,  5,  5,  5,  5,  4,  4,  4,  4,  3,  3,  3,  3,  8,  8,  8,  3,  3,  3,  2,  2};
  localparam string TT  [N] = '{"R3","R3","R3","R3","R1","R1","R1","R1","R1","R1","R5","R5","R5","R5",
                                "R6","R6","R6","R7","R7","R7","R8","R8"};

  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [W-1:0] in_word = '0;
  logic [CW-1:0] rank_k = 1, win_size = 1;
  logic out_valid;
  logic [W-1:0] out_word;

  rank_order_filter #(.W(W), .M(M)) dut (.*);

  always #10 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  int hist[M];
  int mfill = 0;
  int qexp[$], qstamp[$];
  string qtag[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic model(int w, int k, int ws, string tag);
    int tmp[M];
    int t;
    for (int i = M-1; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = w;
    if (mfill < M) mfill++;
    if (mfill >= ws) begin
      for (int i = 0; i < ws; i++) tmp[i] = hist[i];
      for (int a = 0; a < ws; a++)
        for (int b = 0; b < ws-1-a; b++)
          if (tmp[b] < tmp[b+1]) begin t = tmp[b]; tmp[b] = tmp[b+1]; tmp[b+1] = t; end
      qexp.push_back(tmp[k-1]);
      qstamp.push_back(cyc + 1);
      qtag.push_back(tag);
    end
  endtask

  task automatic send(int w, int k, int ws, string tag);
    @(negedge clk);
    in_valid = 1; in_word = W'(w); rank_k = CW'(k); win_size = CW'(ws);
    model(w, k, ws, tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 0; in_word = 8'hA5;
    end
  endtask

  // output monitor: every negedge decides whether a result is due
  always @(negedge clk) begin
    if (!rst_n) begin
      checks++;
      if (out_valid !== 1'b0) begin
        errors++;
        $display("FAIL R4: out_valid=%0b expected 0 during reset", out_valid);
      end
    end else if (qexp.size() > 0 && qstamp[0] + W - 1 == cyc) begin
      checks++;
      if (out_valid !== 1'b1 || out_word !== W'(qexp[0])) begin
        errors++;
        $display("FAIL %s/R2: valid=%0b word=%0d expected valid=1 word=%0d",
                 qtag[0], out_valid, out_word, qexp[0]);
      end
      void'(qexp.pop_front()); void'(qstamp.pop_front()); void'(qtag.pop_front());
    end else begin
      checks++;
      if (out_valid !== 1'b0) begin
        errors++;
        $display("FAIL R3/R9: out_valid=%0b word=%0d expected no result", out_valid, out_word);
      end
    end
  end

  initial begin
    #(20ns * 150000);
    errors++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // table walk: R1 examples, rank changes in flight (R5), extremes (R6), ties (R7), short window (R8)
    for (int n = 0; n < N; n++) send(TW[n], TK[n], TS[n], TT[n]);
    send(3, 1, 1, "R8");
    // R9: idle gap, nothing launched; window kept
    idle(W + 3);
    send(9, 2, 2, "R9");   // window now 9,3 -> second largest 3
    idle(W + 2);
    // R4: reset with results in flight, fill restarts
    send(90, 1, 3, "R4");
    send(91, 1, 3, "R4");
    @(negedge clk);
    in_valid = 0; rst_n = 0;
    qexp.delete(); qstamp.delete(); qtag.delete();
    mfill = 0;
    idle(3);
    rst_n = 1;
    send(7, 3, 3, "R3");
    send(4, 3, 3, "R3");
    send(6, 3, 3, "R3");   // first result after reset: min of 7,4,6 = 4
    send(1, 2, 3, "R1");
    idle(W + 4);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule